// File: doc/BRIEF.md
# DRAM Refresh and Wake-Up Sequencer

This block sits on the controller side of an asynchronous x16 DRAM and keeps its contents alive. It has no part in data transfers. After reset it holds every strobe inactive for a programmable power-up pause. It then asks for a burst of wake-up refresh cycles. After that it raises a refresh request at a fixed interval, so that all 256 rows are refreshed inside the retention period of the memory. Every duration is a parameter counted in clock cycles.

The sequencer does not own the memory pins. It raises `refresh_req` towards an external access arbiter. When the arbiter answers with `grant`, the sequencer runs one whole refresh cycle on the row strobe, the two column strobes, write enable and output enable. It then pulses `done`. Requests that the arbiter holds off are stored in a small debt counter, so a long page burst can finish first. If the debt would grow past its limit, the retention period is treated as overrun: `ready` falls and the wake-up burst runs again.

The default refresh style is column-before-row. A parameter can select a row-only style instead. In that style the block steps its own row counter onto the address pins.

Top module: `dram_refresh_seq`

## Requirements
- R1: After reset is released, `refresh_req`, `busy` and `ready` are 0 and `ras_n`, `cas_l_n`, `cas_h_n` are 1 for exactly PAUSE_CYC clock cycles. `refresh_req` is first seen high after the PAUSE_CYC-th rising edge.
- R2: After the pause, the block requests exactly WAKE_COUNT refresh cycles. `ready` stays 0 until the last of them completes and becomes 1 in the cycle after that cycle's `done` pulse.
- R3: In column-before-row mode both column strobes are low for exactly T_CSR cycles before `ras_n` falls. They stay low for exactly T_CHR cycles after `ras_n` falls and then rise while `ras_n` is still low. `ras_n` stays low for exactly T_RAS cycles.
- R4: After `ras_n` rises it stays high for at least T_RP cycles. A column strobe stays high for at least T_RPC cycles before it falls again.
- R5: `we_n` and `oe_n` are held at 1 at all times. In column-before-row mode `addr` is 0 and `cas_l_n` equals `cas_h_n`.
- R6: A refresh cycle starts only on a rising edge at which both `refresh_req` and `grant` are 1. `busy` is 1 for exactly T_RPC+T_CSR+T_RAS+T_RP cycles per refresh in column-before-row mode, and for T_RPC+T_RAS+T_RP cycles in row-only mode. `done` is a single-cycle pulse in the last busy cycle. While `busy` is 0, all three strobes are 1.
- R7: While `ready` is 1, one refresh is owed every INTERVAL cycles. With `grant` held at 1, N intervals produce N completed refreshes.
- R8: Owed refreshes accumulate while `grant` is 0, up to DEBT_MAX. `refresh_req` stays 1 while any refresh is owed and no cycle is running. Each `done` retires exactly one owed refresh.
- R9: Holding exactly DEBT_MAX owed refreshes leaves `ready` at 1. The next interval tick that arrives without a completion drops `ready` to 0, discards the debt and restarts the WAKE_COUNT burst, after which `ready` returns to 1.
- R10: In row-only mode (RAS_ONLY=1) the column strobes stay 1 and `ras_n` is low for exactly T_RAS cycles. At each fall of `ras_n`, `addr` carries an 8-bit row number that starts at 0 after reset and increases by 1, modulo 256, after every completed refresh.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| grant | input | 1 | Arbiter hands the memory pins to the sequencer |
| refresh_req | output | 1 | A refresh is owed and no cycle is running |
| busy | output | 1 | A refresh cycle is in progress |
| done | output | 1 | One-cycle pulse in the final cycle of a refresh |
| ready | output | 1 | Wake-up burst finished; memory usable |
| ras_n | output | 1 | Row strobe, active low |
| cas_l_n | output | 1 | Lower-byte column strobe, active low |
| cas_h_n | output | 1 | Upper-byte column strobe, active low |
| we_n | output | 1 | Write enable, held inactive |
| oe_n | output | 1 | Output enable, held inactive |
| addr | output | ROW_W | Row number in row-only mode, otherwise 0 |

## Verification
The hardest state to reach is the debt limit. The bench must leave the arbiter silent for exactly DEBT_MAX ticks, observe that `ready` holds, and then let one more tick through so that `ready` falls. The bench locks onto the tick phase by waiting, with `grant` low, for `refresh_req` to rise from an empty debt. It then counts whole and half intervals, so every sample falls midway between ticks. A second instance in row-only mode runs past 256 refreshes so that the row wrap is seen at the address pins.

// File: rtl/drs_pkg.sv
package drs_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_LEAD,
    SQ_CASPRE,
    SQ_OVERLAP,
    SQ_RASHOLD,
    SQ_PRECH
  } sq_state_e;

  typedef enum logic [1:0] {
    PH_PAUSE,
    PH_WAKE,
    PH_RUN
  } phase_e;

  typedef struct packed {
    logic ras_n;
    logic cas_n;
  } strobe_t;

  function automatic strobe_t strobes_of(sq_state_e s);
    strobe_t v;
    v.ras_n = !((s == SQ_OVERLAP) || (s == SQ_RASHOLD));
    v.cas_n = !((s == SQ_CASPRE) || (s == SQ_OVERLAP));
    return v;
  endfunction

endpackage

// File: rtl/drs_interval_timer.sv
module drs_interval_timer #(
  parameter int INTERVAL = 1562
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int IW = $clog2(INTERVAL + 1);
  localparam logic [IW-1:0] RELOAD = IW'(INTERVAL - 1);

  logic [IW-1:0] cnt_q, cnt_d;

  assign tick = run && (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    if (!run || (cnt_q == '0)) cnt_d = RELOAD;
    else                       cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= RELOAD;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/drs_phase_ctrl.sv
module drs_phase_ctrl
  import drs_pkg::*;
#(
  parameter int PAUSE_CYC  = 20000,
  parameter int WAKE_COUNT = 8,
  parameter int DEBT_MAX   = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic cyc_done,
  output logic pending,
  output logic ready
);
  localparam int PW = $clog2(PAUSE_CYC + 1);
  localparam int WW = $clog2(WAKE_COUNT + 1);
  localparam int DW = $clog2(DEBT_MAX + 1);
  localparam logic [PW-1:0] PAUSE_LOAD = PW'(PAUSE_CYC - 1);
  localparam logic [WW-1:0] WAKE_LOAD  = WW'(WAKE_COUNT);
  localparam logic [DW-1:0] DEBT_TOP   = DW'(DEBT_MAX);

  phase_e        ph_q, ph_d;
  logic [PW-1:0] pc_q, pc_d;
  logic [WW-1:0] wk_q, wk_d;
  logic [DW-1:0] dt_q, dt_d;
  logic          add_only, sub_only;

  assign add_only = tick && !cyc_done;
  assign sub_only = cyc_done && !tick;

  always_comb begin
    ph_d = ph_q;
    pc_d = pc_q;
    wk_d = wk_q;
    dt_d = dt_q;
    unique case (ph_q)
      PH_PAUSE: begin
        if (pc_q == '0) begin
          ph_d = PH_WAKE;
          wk_d = WAKE_LOAD;
        end else begin
          pc_d = pc_q - 1'b1;
        end
      end
      PH_WAKE: begin
        if (cyc_done && (wk_q != '0)) begin
          if (wk_q == WW'(1)) begin
            ph_d = PH_RUN;
            dt_d = '0;
          end
          wk_d = wk_q - 1'b1;
        end
      end
      PH_RUN: begin
        if (add_only && (dt_q == DEBT_TOP)) begin
          ph_d = PH_WAKE;
          wk_d = WAKE_LOAD;
          dt_d = '0;
        end else if (add_only) begin
          dt_d = dt_q + 1'b1;
        end else if (sub_only && (dt_q != '0)) begin
          dt_d = dt_q - 1'b1;
        end
      end
      default: ph_d = PH_PAUSE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= PH_PAUSE;
      pc_q <= PAUSE_LOAD;
      wk_q <= '0;
      dt_q <= '0;
    end else begin
      ph_q <= ph_d;
      pc_q <= pc_d;
      wk_q <= wk_d;
      dt_q <= dt_d;
    end
  end

  assign ready   = (ph_q == PH_RUN);
  assign pending = ((ph_q == PH_WAKE) && (wk_q != '0)) ||
                   ((ph_q == PH_RUN)  && (dt_q != '0));
endmodule

// File: rtl/drs_cycle_engine.sv
module drs_cycle_engine
  import drs_pkg::*;
#(
  parameter int RAS_ONLY = 0,
  parameter int ROW_W    = 8,
  parameter int T_RPC    = 1,
  parameter int T_CSR    = 1,
  parameter int T_CHR    = 1,
  parameter int T_RAS    = 3,
  parameter int T_RP     = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             busy,
  output logic             done,
  output logic             ras_n,
  output logic             cas_l_n,
  output logic             cas_h_n,
  output logic [ROW_W-1:0] row
);
  localparam int M1    = (T_RPC > T_CSR) ? T_RPC : T_CSR;
  localparam int M2    = (T_RAS > T_RP) ? T_RAS : T_RP;
  localparam int T_MAX = (M1 > M2) ? M1 : M2;
  localparam int TW    = $clog2(T_MAX + 1);

  sq_state_e     st_q, st_d;
  logic [TW-1:0] tc_q, tc_d;
  logic          last;
  strobe_t       stb_q;

  assign last = (tc_q == '0);

  always_comb begin
    st_d = st_q;
    tc_d = last ? tc_q : tc_q - 1'b1;
    unique case (st_q)
      SQ_IDLE: begin
        if (start) begin
          st_d = SQ_LEAD;
          tc_d = TW'(T_RPC - 1);
        end
      end
      SQ_LEAD: begin
        if (last) begin
          if (RAS_ONLY != 0) begin
            st_d = SQ_RASHOLD;
            tc_d = TW'(T_RAS - 1);
          end else begin
            st_d = SQ_CASPRE;
            tc_d = TW'(T_CSR - 1);
          end
        end
      end
      SQ_CASPRE: begin
        if (last) begin
          st_d = SQ_OVERLAP;
          tc_d = TW'(T_CHR - 1);
        end
      end
      SQ_OVERLAP: begin
        if (last) begin
          st_d = SQ_RASHOLD;
          tc_d = TW'(T_RAS - T_CHR - 1);
        end
      end
      SQ_RASHOLD: begin
        if (last) begin
          st_d = SQ_PRECH;
          tc_d = TW'(T_RP - 1);
        end
      end
      SQ_PRECH: begin
        if (last) st_d = SQ_IDLE;
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SQ_IDLE;
      tc_q  <= '0;
      stb_q <= '{ras_n: 1'b1, cas_n: 1'b1};
    end else begin
      st_q  <= st_d;
      tc_q  <= tc_d;
      stb_q <= strobes_of(st_d);
    end
  end

  assign busy    = (st_q != SQ_IDLE);
  assign done    = (st_q == SQ_PRECH) && last;
  assign ras_n   = stb_q.ras_n;
  assign cas_l_n = stb_q.cas_n;
  assign cas_h_n = stb_q.cas_n;

  generate
    if (RAS_ONLY != 0) begin : g_row_cnt
      logic [ROW_W-1:0] row_q;
      logic             row_en;
      assign row_en = done;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      row_q <= '0;
        else if (row_en) row_q <= row_q + 1'b1;
      end
      assign row = row_q;
    end else begin : g_no_row
      assign row = '0;
    end
  endgenerate
endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq #(
  parameter int RAS_ONLY   = 0,
  parameter int ROW_W      = 8,
  parameter int PAUSE_CYC  = 20000,
  parameter int WAKE_COUNT = 8,
  parameter int INTERVAL   = 1562,
  parameter int DEBT_MAX   = 8,
  parameter int T_RPC      = 1,
  parameter int T_CSR      = 1,
  parameter int T_CHR      = 1,
  parameter int T_RAS      = 3,
  parameter int T_RP       = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             grant,
  output logic             refresh_req,
  output logic             busy,
  output logic             done,
  output logic             ready,
  output logic             ras_n,
  output logic             cas_l_n,
  output logic             cas_h_n,
  output logic             we_n,
  output logic             oe_n,
  output logic [ROW_W-1:0] addr
);
  logic tick, pending, start;

  drs_interval_timer #(.INTERVAL(INTERVAL)) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (ready),
    .tick (tick)
  );

  drs_phase_ctrl #(
    .PAUSE_CYC (PAUSE_CYC),
    .WAKE_COUNT(WAKE_COUNT),
    .DEBT_MAX  (DEBT_MAX)
  ) u_phase (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .cyc_done(done),
    .pending (pending),
    .ready   (ready)
  );

  assign refresh_req = pending && !busy;
  assign start       = refresh_req && grant;

  drs_cycle_engine #(
    .RAS_ONLY(RAS_ONLY),
    .ROW_W   (ROW_W),
    .T_RPC   (T_RPC),
    .T_CSR   (T_CSR),
    .T_CHR   (T_CHR),
    .T_RAS   (T_RAS),
    .T_RP    (T_RP)
  ) u_engine (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .busy   (busy),
    .done   (done),
    .ras_n  (ras_n),
    .cas_l_n(cas_l_n),
    .cas_h_n(cas_h_n),
    .row    (addr)
  );

  assign we_n = 1'b1;
  assign oe_n = 1'b1;
endmodule

// File: rtl/drs_checks.sv
module drs_checks #(
  parameter int RAS_ONLY = 0
) (
  input logic clk,
  input logic rst_n,
  input logic grant,
  input logic refresh_req,
  input logic busy,
  input logic done,
  input logic ready,
  input logic ras_n,
  input logic cas_l_n,
  input logic cas_h_n
);
  generate
    if (RAS_ONLY == 0) begin : g_cbr
      AST_CAS_LEADS_RAS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> (!cas_l_n && !cas_h_n)); // R3
      AST_CAS_RISES_UNDER_RAS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cas_l_n) |-> !ras_n); // R3
    end else begin : g_ronly
      AST_RASONLY_CAS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> (cas_l_n && cas_h_n)); // R10
    end
  endgenerate

  AST_PRECHARGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |=> ras_n); // R4
  AST_START_NEEDS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(grant && refresh_req)); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (ras_n && cas_l_n && cas_h_n)); // R6
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6
  AST_READY_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(done)); // R2
endmodule

bind dram_refresh_seq drs_checks #(.RAS_ONLY(RAS_ONLY)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .grant      (grant),
  .refresh_req(refresh_req),
  .busy       (busy),
  .done       (done),
  .ready      (ready),
  .ras_n      (ras_n),
  .cas_l_n    (cas_l_n),
  .cas_h_n    (cas_h_n)
);

// File: tb/sim_dram_refresh_seq.sv
module sim_dram_refresh_seq;
  localparam int CLK_PERIOD = 10;
  localparam int P      = 20;
  localparam int W      = 8;
  localparam int I0     = 100;
  localparam int I1     = 20;
  localparam int D      = 4;
  localparam int T_RPC  = 1;
  localparam int T_CSR  = 2;
  localparam int T_CHR  = 3;
  localparam int T_RAS  = 6;
  localparam int T_RP   = 4;
  localparam int CYC0   = T_RPC + T_CSR + T_RAS + T_RP;
  localparam int CYC1   = T_RPC + T_RAS + T_RP;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic gnt0 = 1'b0;
  logic gnt1 = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic req0, busy0, done0, ready0, ras0, casl0, cash0, we0, oe0;
  logic req1, busy1, done1, ready1, ras1, casl1, cash1, we1, oe1;
  logic [7:0] addr0, addr1;

  dram_refresh_seq #(.RAS_ONLY(0), .PAUSE_CYC(P), .WAKE_COUNT(W), .INTERVAL(I0),
    .DEBT_MAX(D), .T_RPC(T_RPC), .T_CSR(T_CSR), .T_CHR(T_CHR), .T_RAS(T_RAS), .T_RP(T_RP)) u0 (
    .clk(clk), .rst_n(rst_n), .grant(gnt0), .refresh_req(req0), .busy(busy0), .done(done0),
    .ready(ready0), .ras_n(ras0), .cas_l_n(casl0), .cas_h_n(cash0), .we_n(we0), .oe_n(oe0),
    .addr(addr0));

  dram_refresh_seq #(.RAS_ONLY(1), .PAUSE_CYC(P), .WAKE_COUNT(W), .INTERVAL(I1),
    .DEBT_MAX(D), .T_RPC(T_RPC), .T_CSR(T_CSR), .T_CHR(T_CHR), .T_RAS(T_RAS), .T_RP(T_RP)) u1 (
    .clk(clk), .rst_n(rst_n), .grant(gnt1), .refresh_req(req1), .busy(busy1), .done(done1),
    .ready(ready1), .ras_n(ras1), .cas_l_n(casl1), .cas_h_n(cash1), .we_n(we1), .oe_n(oe1),
    .addr(addr1));

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // column-before-row instance monitor
  int c0_cas_low, c0_cas_high, c0_ras_low, c0_ras_high, c0_busy, bad_side0;
  logic p_ras0, p_cas0, p_busy0;
  always @(negedge clk) begin
    if (!rst_n) begin
      c0_cas_low = 0; c0_cas_high = 0; c0_ras_low = 0; c0_ras_high = 0; c0_busy = 0;
      bad_side0 = 0; p_ras0 = 1'b1; p_cas0 = 1'b1; p_busy0 = 1'b0;
    end else begin
      if (p_ras0 && !ras0) begin
        chk(c0_cas_low == T_CSR, "R3 column lead before row fall", c0_cas_low, T_CSR);
        chk(c0_ras_high >= T_RP, "R4 row precharge", c0_ras_high, T_RP);
      end
      if (!p_cas0 && casl0)
        chk(c0_ras_low == T_CHR && !ras0, "R3 column hold after row fall", c0_ras_low, T_CHR);
      if (p_cas0 && !casl0)
        chk(c0_cas_high >= T_RPC, "R4 row-to-column precharge", c0_cas_high, T_RPC);
      if (!p_ras0 && ras0)
        chk(c0_ras_low == T_RAS, "R3 row low width", c0_ras_low, T_RAS);
      if (p_busy0 && !busy0)
        chk(c0_busy == CYC0, "R6 busy length", c0_busy, CYC0);
      if ((casl0 != cash0) || !we0 || !oe0 || (addr0 != 8'd0)) bad_side0++;
      c0_cas_low  = casl0 ? 0 : c0_cas_low + 1;
      c0_cas_high = casl0 ? c0_cas_high + 1 : 0;
      c0_ras_low  = ras0 ? 0 : c0_ras_low + 1;
      c0_ras_high = ras0 ? c0_ras_high + 1 : 0;
      c0_busy     = busy0 ? c0_busy + 1 : 0;
      p_ras0 = ras0; p_cas0 = casl0; p_busy0 = busy0;
    end
  end

  // row-only instance monitor
  int c1_ras_low, c1_busy, n1, bad_cas1, bad_side1;
  logic [7:0] exp_row;
  logic p_ras1, p_busy1;
  always @(negedge clk) begin
    if (!rst_n) begin
      c1_ras_low = 0; c1_busy = 0; n1 = 0; bad_cas1 = 0; bad_side1 = 0;
      exp_row = 8'd0; p_ras1 = 1'b1; p_busy1 = 1'b0;
    end else begin
      if (p_ras1 && !ras1)
        chk(addr1 == exp_row, "R10 row address", addr1, exp_row);
      if (!p_ras1 && ras1) begin
        chk(c1_ras_low == T_RAS, "R10 row low width", c1_ras_low, T_RAS);
        exp_row = exp_row + 8'd1;
        n1++;
      end
      if (p_busy1 && !busy1)
        chk(c1_busy == CYC1, "R6 busy length row-only", c1_busy, CYC1);
      if (!casl1 || !cash1) bad_cas1++;
      if (!we1 || !oe1) bad_side1++;
      c1_ras_low = ras1 ? 0 : c1_ras_low + 1;
      c1_busy    = busy1 ? c1_busy + 1 : 0;
      p_ras1 = ras1; p_busy1 = busy1;
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog R1..: actual %0d expected %0d", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    int n, dn;
    bit ok;
    repeat (3) @(negedge clk);
    chk({ras0, casl0, cash0, ready0, req0, busy0} == 6'b111000, "R1 reset state",
        {ras0, casl0, cash0, ready0, req0, busy0}, 6'b111000);
    rst_n = 1'b1;

    // R1 pause length
    n = 0; ok = 1'b1;
    while (!req0 && n < 1000) begin
      @(posedge clk); @(negedge clk);
      n++;
      if (!ras0 || !casl0 || !cash0 || ready0 || busy0) ok = 1'b0;
    end
    chk(n == P, "R1 pause length", n, P);
    chk(ok, "R1 strobes quiet during pause", ok, 1);

    // R6 nothing starts without grant
    ok = 1'b1;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      if (!ras0 || !casl0 || busy0 || !req0) ok = 1'b0;
    end
    chk(ok, "R6 no cycle without grant", ok, 1);

    // R2 wake burst
    gnt0 = 1'b1; n = 0; dn = 0;
    while (!ready0 && n < 2000) begin
      @(negedge clk);
      n++;
      if (done0) dn++;
    end
    chk(dn == W, "R2 wake burst count", dn, W);
    chk(ready0 == 1'b1, "R2 ready after burst", ready0, 1);

    // R7 periodic refresh
    dn = 0;
    for (int k = 0; k < 10 * I0 + I0 / 2; k++) begin
      @(negedge clk);
      if (done0) dn++;
    end
    chk(dn == 10, "R7 refreshes per ten intervals", dn, 10);
    chk(ready0 == 1'b1, "R7 ready kept", ready0, 1);

    // R8 debt accumulation and drain
    gnt0 = 1'b0;
    repeat (3 * I0) @(negedge clk);
    chk(req0 && !busy0, "R8 request held while withheld", req0, 1);
    gnt0 = 1'b1; dn = 0; n = 0;
    do begin
      @(negedge clk);
      n++;
      if (done0) dn++;
    end while ((req0 || busy0) && n < 300);
    chk(dn == 3, "R8 drained refresh count", dn, 3);

    // R9 debt limit and forced wake-up
    gnt0 = 1'b0; n = 0;
    while (!req0 && n < 300) begin
      @(negedge clk);
      n++;
    end
    repeat (3 * I0 + I0 / 2) @(negedge clk);
    chk(ready0 == 1'b1, "R9 full debt keeps ready", ready0, 1);
    repeat (I0) @(negedge clk);
    chk(ready0 == 1'b0, "R9 overflow drops ready", ready0, 0);
    chk(req0 == 1'b1, "R9 wake-up requested", req0, 1);
    gnt0 = 1'b1; dn = 0; n = 0;
    while (!ready0 && n < 2000) begin
      @(negedge clk);
      n++;
      if (done0) dn++;
    end
    chk(dn == W, "R9 repeated wake burst count", dn, W);

    // R10 row wrap on the row-only instance
    n = 0;
    while (n1 < 260 && n < 20000) begin
      @(negedge clk);
      n++;
    end
    chk(n1 >= 260, "R10 row counter wrapped", n1, 260);
    chk(bad_cas1 == 0, "R10 column strobes idle", bad_cas1, 0);
    chk(bad_side0 == 0, "R5 side pins column-before-row", bad_side0, 0);
    chk(bad_side1 == 0, "R5 side pins row-only", bad_side1, 0);

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule